// File: doc/BRIEF.md
# UART Transmitter with Break Control

This block turns bytes into asynchronous serial frames. Bytes are written into a small transmit queue. A serializer takes them out one at a time and shifts each one onto a line that rests high. Each frame has a low start bit, eight data bits sent least significant bit first, an optional parity bit and one or two high stop bits. Every bit lasts eight periods of an oversample enable pulse, which comes from an external baud divider. A write that arrives while the queue is full is dropped.

Several controls decide when a new frame may begin: a run enable, a clear-to-send gate that applies when flow control is switched on, a line-break request and a queue flush. None of them cuts a frame short. A frame that has started always finishes its stop bits. The break request then holds the line low and leaves the queued bytes untouched. The flush empties the queue. A done flag reports that the serializer is idle and the queue is empty, so a controller can hold the flush until that flag is seen.

Top module: `uart_txe`

## Requirements
- R1: After reset, `txd` is 1, `fifo_empty` is 1 and `tx_done` is 1.
- R2: A frame is a start bit at 0, then the eight data bits starting with bit 0, then the trailing bits. Each bit lasts 8 `os_tick` pulses. Queued bytes go out in write order, and each frame starts on the clock after the previous one ends.
- R3: Stop-bit code `stop_code` 2'b01 gives one stop bit and 2'b10 gives two stop bits. The unused codes 2'b00 and 2'b11 both give one stop bit.
- R4: With `par_en`=1, one parity bit follows the data bits. It equals the XOR of the eight data bits when `par_odd`=0 (even parity), and the inverse of that XOR when `par_odd`=1.
- R5: Code 2'b10 together with `par_en`=1 gives one stop bit.
- R6: While `flow_en`=1 and `cts_ready`=0, no frame starts and queued bytes stay queued. Raising `cts_ready` lets them go. With `flow_en`=0, `cts_ready` has no effect.
- R7: While `enable`=0, no new frame starts. A frame already on the line completes, and queued bytes are kept and sent after `enable` returns to 1.
- R8: A `break_req` raised while idle drives `txd` to 0 on the next clock. A `break_req` raised during a frame lets that frame finish, including its stop bits, and then drives `txd` to 0. The line stays at 0 until `break_req` falls.
- R9: While `break_req` is 1, no byte is taken from the queue. After it falls, the queued bytes are sent in order.
- R10: With `flush_req`=1 the queue reads as empty from the next clock. Writes made while `flush_req` is 1 are dropped, including a write in the same cycle the flush starts. A frame already on the line still completes.
- R11: `tx_done` is 1 only when the serializer is neither sending nor breaking and the queue is empty. It is 0 while a frame or a break is on the line, and it follows the state one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversample enable pulse; 8 pulses per bit |
| enable | input | 1 | Allows new frames to start |
| stop_code | input | 2 | Stop-bit count code |
| par_en | input | 1 | Adds a parity bit |
| par_odd | input | 1 | Selects odd parity (1) or even parity (0) |
| flow_en | input | 1 | Makes frame starts depend on `cts_ready` |
| cts_ready | input | 1 | Far end is ready to receive |
| break_req | input | 1 | Hold the line low once the current frame has finished |
| flush_req | input | 1 | Empty the queue and drop writes |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to queue |
| fifo_empty | output | 1 | Queue holds no byte |
| tx_done | output | 1 | Serializer idle and queue empty |
| txd | output | 1 | Serial line, idle high |

## Verification
Two pairs of events can land in the same cycle. The first is a byte write and the start of a flush. The bench drives `wr_en` and `flush_req` on the same clock and then confirms that `fifo_empty` is high on the next clock and that no frame leaves the line after the flush and the hold on `enable` are released. The second is a break request and a frame in progress. The bench raises `break_req` part way through a frame with more bytes queued. It then judges that the frame decodes intact, that the line stays low, that the queue stays non-empty and `tx_done` stays low, and that the remaining bytes go out in order once the break is dropped.

// File: rtl/uart_txe_pkg.sv
package uart_txe_pkg;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_SEND  = 2'd1,
    TX_BREAK = 2'd2
  } tx_state_e;

  localparam logic [1:0] STOP_CODE_ONE = 2'b01;
  localparam logic [1:0] STOP_CODE_TWO = 2'b10;

endpackage

// File: rtl/uart_txe_fifo.sv
module uart_txe_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          pop,
  output logic [DW-1:0] rd_data,
  output logic          empty
);

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          full, push, take;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign push  = wr_en && !full && !flush;
  assign take  = pop && !empty && !flush;

  // storage without reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (take) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push, take})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty);  // R10

  AST_NO_POP_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);  // R9

endmodule

// File: rtl/uart_txe_serializer.sv
module uart_txe_serializer
  import uart_txe_pkg::*;
#(
  parameter int unsigned DW            = 8,
  parameter int unsigned TICKS_PER_BIT = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          os_tick,
  input  logic          enable,
  input  logic [1:0]    stop_code,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          flow_en,
  input  logic          cts_ready,
  input  logic          break_req,
  input  logic          flush_req,
  input  logic          fifo_empty,
  input  logic [DW-1:0] fifo_data,
  output logic          pop,
  output logic          txd,
  output logic          tx_done
);

  localparam int unsigned FW  = DW + 4;
  localparam int unsigned BCW = $clog2(FW + 1);
  localparam int unsigned TW  = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam logic [TW-1:0] TICK_LAST = TW'(TICKS_PER_BIT - 1);

  tx_state_e      state;
  logic [FW-1:0]  shreg, frame_n;
  logic [TW-1:0]  tick_cnt;
  logic [BCW-1:0] bits_left, nbits_n;
  logic           start, two_stop;

  assign start = (state == TX_IDLE) && !break_req && enable && !fifo_empty
                 && !flush_req && (!flow_en || cts_ready);
  assign pop   = start;

  assign two_stop = (stop_code == STOP_CODE_TWO) && !par_en;

  always_comb begin
    frame_n         = '1;
    frame_n[0]      = 1'b0;
    frame_n[DW:1]   = fifo_data;
    if (par_en) frame_n[DW+1] = (^fifo_data) ^ par_odd;
    nbits_n = BCW'(DW + 2) + BCW'(par_en) + BCW'(two_stop);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= TX_IDLE;
      txd       <= 1'b1;
      shreg     <= '1;
      tick_cnt  <= '0;
      bits_left <= '0;
      tx_done   <= 1'b1;
    end else begin
      tx_done <= (state == TX_IDLE) && !break_req && fifo_empty && !start;
      case (state)
        TX_IDLE: begin
          if (break_req) begin
            state <= TX_BREAK;
            txd   <= 1'b0;
          end else if (start) begin
            state     <= TX_SEND;
            shreg     <= frame_n;
            txd       <= 1'b0;
            tick_cnt  <= '0;
            bits_left <= nbits_n - 1'b1;
          end
        end
        TX_SEND: begin
          if (os_tick) begin
            if (tick_cnt == TICK_LAST) begin
              tick_cnt <= '0;
              if (bits_left == '0) begin
                state <= break_req ? TX_BREAK : TX_IDLE;
                txd   <= !break_req;
              end else begin
                shreg     <= {1'b1, shreg[FW-1:1]};
                txd       <= shreg[1];
                bits_left <= bits_left - 1'b1;
              end
            end else begin
              tick_cnt <= tick_cnt + 1'b1;
            end
          end
        end
        TX_BREAK: begin
          if (!break_req) begin
            state <= TX_IDLE;
            txd   <= 1'b1;
          end
        end
        default: begin
          state <= TX_IDLE;
          txd   <= 1'b1;
        end
      endcase
    end
  end

  AST_BREAK_HOLDS_LOW: assert property (@(posedge clk) disable iff (rst)
    (break_req && state != TX_SEND) |=> !txd);  // R8

  AST_BREAK_KEEPS_QUEUE: assert property (@(posedge clk) disable iff (rst)
    break_req |-> !pop);  // R9

  AST_FLOW_BLOCKS_START: assert property (@(posedge clk) disable iff (rst)
    (flow_en && !cts_ready) |-> !pop);  // R6

  AST_DISABLED_NO_START: assert property (@(posedge clk) disable iff (rst)
    !enable |-> !pop);  // R7

  AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (rst)
    pop |=> !txd);  // R2

  AST_DONE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> txd);  // R11

  AST_SEND_NOT_DONE: assert property (@(posedge clk) disable iff (rst)
    (state == TX_SEND) |-> !tx_done);  // R11

endmodule

// File: rtl/uart_txe.sv
module uart_txe #(
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned FIFO_DEPTH    = 8,
  parameter int unsigned TICKS_PER_BIT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              os_tick,
  input  logic              enable,
  input  logic [1:0]        stop_code,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              flow_en,
  input  logic              cts_ready,
  input  logic              break_req,
  input  logic              flush_req,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              fifo_empty,
  output logic              tx_done,
  output logic              txd
);

  logic [DATA_W-1:0] q_data;
  logic              q_pop;

  uart_txe_fifo #(
    .DW    (DATA_W),
    .DEPTH (FIFO_DEPTH)
  ) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .flush   (flush_req),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .pop     (q_pop),
    .rd_data (q_data),
    .empty   (fifo_empty)
  );

  uart_txe_serializer #(
    .DW            (DATA_W),
    .TICKS_PER_BIT (TICKS_PER_BIT)
  ) u_ser (
    .clk        (clk),
    .rst        (rst),
    .os_tick    (os_tick),
    .enable     (enable),
    .stop_code  (stop_code),
    .par_en     (par_en),
    .par_odd    (par_odd),
    .flow_en    (flow_en),
    .cts_ready  (cts_ready),
    .break_req  (break_req),
    .flush_req  (flush_req),
    .fifo_empty (fifo_empty),
    .fifo_data  (q_data),
    .pop        (q_pop),
    .txd        (txd),
    .tx_done    (tx_done)
  );

endmodule

// File: tb/uart_txe_bench.sv
`timescale 1ns/1ps
module uart_txe_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       os_tick = 1'b0;
  logic       enable = 1'b0;
  logic [1:0] stop_code = 2'b01;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       flow_en = 1'b0;
  logic       cts_ready = 1'b0;
  logic       break_req = 1'b0;
  logic       flush_req = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       fifo_empty, tx_done, txd;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // monitor state
  logic [7:0] rx_d [64];
  logic       rx_p [64];
  int         rx_t [64];
  int         rx_n = 0;
  int         brk_cnt = 0;
  logic       mon_par = 1'b0;
  logic [7:0] md;
  logic       mp, mpar_now;
  int         mt0;

  uart_txe u_uart_txe (
    .clk (clk), .rst (rst), .os_tick (os_tick), .enable (enable),
    .stop_code (stop_code), .par_en (par_en), .par_odd (par_odd),
    .flow_en (flow_en), .cts_ready (cts_ready), .break_req (break_req),
    .flush_req (flush_req), .wr_en (wr_en), .wr_data (wr_data),
    .fifo_empty (fifo_empty), .tx_done (tx_done), .txd (txd)
  );

  always #2.5 clk = ~clk;

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  // oversample pulse: one clock high, one clock low
  initial forever begin
    @(negedge clk);
    os_tick = rst ? 1'b0 : ~os_tick;
  end

  // line decoder: bit = 8 ticks = 16 clocks, sample at bit centres
  initial forever begin
    @(negedge clk);
    if (!rst && txd === 1'b0) begin
      mt0 = cyc;
      mpar_now = mon_par;
      repeat (8) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
        repeat (16) @(negedge clk);
        md[i] = txd;
      end
      mp = 1'b0;
      if (mpar_now) begin
        repeat (16) @(negedge clk);
        mp = txd;
      end
      repeat (16) @(negedge clk);
      if (txd === 1'b1) begin
        if (rx_n < 64) begin
          rx_d[rx_n] = md;
          rx_p[rx_n] = mp;
          rx_t[rx_n] = mt0;
        end
        rx_n++;
      end else begin
        brk_cnt++;
        while (txd !== 1'b1) @(negedge clk);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all): actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_done();
    repeat (3) @(negedge clk);
    while (tx_done !== 1'b1) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_start();
    @(negedge clk);
    while (txd !== 1'b0) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(txd === 1'b1, "R1", "txd after reset", txd, 1);
    chk(fifo_empty === 1'b1, "R1", "fifo_empty after reset", fifo_empty, 1);
    chk(tx_done === 1'b1, "R1", "tx_done after reset", tx_done, 1);
  endtask

  // send two bytes with a given format and judge data, parity and frame length
  task automatic t_pair(input logic [1:0] sc, input logic pe, input logic po,
                        input logic [7:0] b0, input logic [7:0] b1,
                        input int nbits, input string req);
    int sp;
    stop_code = sc; par_en = pe; par_odd = po; mon_par = pe;
    enable = 1'b1;
    rx_n = 0;
    put(b0);
    put(b1);
    @(negedge clk);
    chk(tx_done === 1'b0, "R11", "tx_done while sending", tx_done, 0);
    wait_done();
    chk(rx_n == 2, "R2", "frames received", rx_n, 2);
    chk(rx_d[0] == b0, "R2", "first byte", rx_d[0], b0);
    chk(rx_d[1] == b1, "R2", "second byte", rx_d[1], b1);
    sp = rx_t[1] - rx_t[0];
    chk(sp >= nbits*16 - 2 && sp <= nbits*16 + 2, req, "frame length in clocks",
        sp, nbits*16);
    if (pe) begin
      chk(rx_p[0] == ((^b0) ^ po), "R4", "parity of first byte", rx_p[0], (^b0) ^ po);
      chk(rx_p[1] == ((^b1) ^ po), "R4", "parity of second byte", rx_p[1], (^b1) ^ po);
    end
  endtask

  task automatic t_flow();
    stop_code = 2'b01; par_en = 1'b0; mon_par = 1'b0;
    enable = 1'b1; flow_en = 1'b1; cts_ready = 1'b0;
    rx_n = 0;
    put(8'h5A);
    repeat (300) @(negedge clk);
    chk(rx_n == 0, "R6", "frames while cts low", rx_n, 0);
    chk(fifo_empty === 1'b0, "R6", "byte held in queue", fifo_empty, 0);
    cts_ready = 1'b1;
    wait_done();
    chk(rx_n == 1 && rx_d[0] == 8'h5A, "R6", "byte after cts high", rx_d[0], 8'h5A);
    flow_en = 1'b0; cts_ready = 1'b0;
    rx_n = 0;
    put(8'hC3);
    wait_done();
    chk(rx_n == 1 && rx_d[0] == 8'hC3, "R6", "cts ignored with flow off", rx_d[0], 8'hC3);
  endtask

  task automatic t_enable();
    stop_code = 2'b01; par_en = 1'b0; mon_par = 1'b0;
    enable = 1'b0;
    rx_n = 0;
    put(8'h11);
    put(8'h22);
    repeat (300) @(negedge clk);
    chk(rx_n == 0, "R7", "frames while disabled", rx_n, 0);
    chk(fifo_empty === 1'b0, "R7", "bytes kept while disabled", fifo_empty, 0);
    enable = 1'b1;
    wait_start();
    repeat (20) @(negedge clk);
    enable = 1'b0;
    repeat (400) @(negedge clk);
    chk(rx_n == 1 && rx_d[0] == 8'h11, "R7", "frame in progress completes", rx_d[0], 8'h11);
    chk(fifo_empty === 1'b0, "R7", "second byte kept", fifo_empty, 0);
    chk(txd === 1'b1, "R7", "line idle after stop", txd, 1);
    enable = 1'b1;
    wait_done();
    chk(rx_n == 2 && rx_d[1] == 8'h22, "R7", "kept byte sent later", rx_d[1], 8'h22);
  endtask

  task automatic t_break();
    stop_code = 2'b01; par_en = 1'b0; mon_par = 1'b0;
    enable = 1'b1;
    // break from idle
    rx_n = 0; brk_cnt = 0;
    @(negedge clk);
    break_req = 1'b1;
    @(negedge clk);
    chk(txd === 1'b0, "R8", "line low one clock after idle break", txd, 0);
    chk(tx_done === 1'b0, "R11", "tx_done low during break", tx_done, 0);
    repeat (250) @(negedge clk);
    break_req = 1'b0;
    @(negedge clk);
    chk(txd === 1'b1, "R8", "line high after break release", txd, 1);
    repeat (20) @(negedge clk);
    chk(rx_n == 0, "R8", "idle break decodes as no byte", rx_n, 0);
    // break during a frame with bytes queued
    rx_n = 0;
    put(8'h31);
    put(8'h32);
    put(8'h33);
    wait_start();
    repeat (20) @(negedge clk);
    break_req = 1'b1;
    repeat (600) @(negedge clk);
    chk(rx_n == 1 && rx_d[0] == 8'h31, "R8", "current frame completes", rx_d[0], 8'h31);
    chk(txd === 1'b0, "R8", "line held low", txd, 0);
    chk(fifo_empty === 1'b0, "R9", "queue kept during break", fifo_empty, 0);
    chk(tx_done === 1'b0, "R11", "tx_done low during break", tx_done, 0);
    break_req = 1'b0;
    wait_done();
    chk(rx_n == 3, "R9", "frames after release", rx_n, 3);
    chk(rx_d[1] == 8'h32 && rx_d[2] == 8'h33, "R9", "order after release",
        rx_d[1], 8'h32);
  endtask

  task automatic t_flush();
    stop_code = 2'b01; par_en = 1'b0; mon_par = 1'b0;
    enable = 1'b0;
    rx_n = 0;
    put(8'h01); put(8'h02); put(8'h03); put(8'h04);
    // write and flush in the same cycle
    @(negedge clk);
    wr_en = 1'b1; wr_data = 8'hEE; flush_req = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    chk(fifo_empty === 1'b1, "R10", "queue empty after flush", fifo_empty, 1);
    repeat (3) @(negedge clk);
    chk(tx_done === 1'b1, "R11", "tx_done after flush while idle", tx_done, 1);
    flush_req = 1'b0;
    enable = 1'b1;
    repeat (400) @(negedge clk);
    chk(rx_n == 0, "R10", "nothing sent after flush", rx_n, 0);
    // flush during a frame
    put(8'h41); put(8'h42); put(8'h43);
    wait_start();
    repeat (10) @(negedge clk);
    flush_req = 1'b1;
    @(negedge clk);
    chk(fifo_empty === 1'b1, "R10", "queue empty mid-frame", fifo_empty, 1);
    chk(tx_done === 1'b0, "R11", "tx_done low while frame runs", tx_done, 0);
    wait_done();
    flush_req = 1'b0;
    repeat (300) @(negedge clk);
    chk(rx_n == 1 && rx_d[0] == 8'h41, "R10", "running frame completes only",
        rx_n, 1);
  endtask

  initial begin
    t_reset();
    t_pair(2'b01, 1'b0, 1'b0, 8'hA5, 8'h3C, 10, "R3");
    t_pair(2'b10, 1'b0, 1'b0, 8'h55, 8'hAA, 11, "R3");
    t_pair(2'b00, 1'b0, 1'b0, 8'h0F, 8'hF0, 10, "R3");
    t_pair(2'b11, 1'b0, 1'b0, 8'h80, 8'h01, 10, "R3");
    t_pair(2'b01, 1'b1, 1'b0, 8'hA5, 8'h07, 11, "R4");
    t_pair(2'b01, 1'b1, 1'b1, 8'hA5, 8'h07, 11, "R4");
    t_pair(2'b10, 1'b1, 1'b0, 8'h81, 8'h7E, 11, "R5");
    t_flow();
    t_enable();
    t_break();
    t_flush();
    summary();
    $finish;
  end

endmodule